// File: doc/BRIEF.md
# Cartridge Serial Port Register Front End

This block sits between a CPU bus and a byte-wide serial link to a removable memory module. Software sees a 16-bit control register at offset 0 and an 8-bit data register at offset 2. The bus can reach these registers with byte, halfword or word accesses. Each accepted data write becomes a single one-cycle byte transfer on the slave side. The transfer carries a chip-hold flag. The byte the slave returns in that same cycle is captured, and later data reads return it.

Two CPUs share the block. An ownership input names which CPU may write the control register. The data register has no ownership gate, but it is closed unless the control register has both the enable bit and the serial-mode bit set. Serial clocking and transfer delays are not modelled, so every transfer completes in the cycle it is issued.

Bus data is right-aligned: a byte value always travels in `bus_wdata[7:0]` and `bus_rdata[7:0]`, whatever its offset. Size codes: 0 = byte, 1 = halfword, 2 = word.

Top module: `cart_spi_regif`

## Requirements
- R1: A control write keeps only bits 15, 14, 13, 6, 1 and 0 of the written value (mask 0xE043). All other control bits, except bit 7, read back as 0.
- R2: Control bit 7 (busy) is 0 after reset and no write of any size changes it.
- R3: A data read (byte or halfword at offset 2, or bits 23:16 of a word read at offset 0) returns 0x00 unless control bit 15 (enable) and bit 13 (serial mode) are both 1. When both are 1 it returns the last received byte.
- R4: When the gate is open, a data write raises `slv_valid` in that same cycle. `slv_byte` carries the written low byte and `slv_hold` equals control bit 6. The `slv_rx` value at that clock edge becomes the received byte, which can be read in the next cycle.
- R5: When the gate is closed, a data write raises no `slv_valid` and leaves the received byte unchanged.
- R6: Control writes take effect only when `bus_cpu` equals `owner_sel`. A non-owner control write leaves the control value unchanged. Byte and halfword data writes at offset 2 are accepted from either CPU.
- R7: A byte write at offset 0 changes only control bits 7:0, and a byte write at offset 1 changes only bits 15:8; both still pass through the R1 mask. A byte write at offset 3 changes nothing.
- R8: A word write at offset 0 by the owner loads control from bits 15:0 and sends bits 23:16 as a data byte in the same cycle. The new control value decides the gate and the hold flag. A non-owner word write does nothing.
- R9: A word read at offset 0 returns {8'h00, data byte, control}. A byte read at offset 0 or 1 returns the low or high control byte. A halfword read at offset 0 returns control. Reads at any other size/offset pair return 0. Reset clears control and the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | 1 | Index of the requesting CPU |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 2 | Byte offset within the register window |
| bus_wdata | input | 32 | Right-aligned write value |
| bus_rdata | output | 32 | Right-aligned read value (combinational) |
| owner_sel | input | 1 | CPU that owns the control register |
| slv_valid | output | 1 | Byte transfer strobe to the slave |
| slv_byte | output | 8 | Byte sent to the slave |
| slv_hold | output | 1 | Chip-hold flag for this transfer |
| slv_rx | input | 8 | Byte returned by the slave in the strobe cycle |

## Verification
A word write at offset 0 updates control and issues a transfer in the same cycle. The transfer must be gated, and its hold flag taken, from the control value being written, not the one held in the register. Directed word writes cover three cases: a write that opens the gate while it was closed, a write that closes it while it was open, and a non-owner word write that must do nothing. Random word writes then mix both outcomes. The bench model computes the next control value first and derives the expected strobe, byte and hold from it, so a design that uses the stale control value is caught at the slave pins.

// File: rtl/cspi_pkg.sv
package cspi_pkg;
   localparam int BUS_W = 32;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;
endpackage

// File: rtl/cspi_ctrl_reg.sv
module cspi_ctrl_reg #(
   parameter int          CTRL_W    = 16,
   parameter logic [15:0] CTRL_MASK = 16'hE043,
   parameter int          BUSY_BIT  = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CTRL_W/8-1:0] lane_we,
   input  logic [CTRL_W-1:0]   wval,
   output logic [CTRL_W-1:0]   q,
   output logic [CTRL_W-1:0]   nxt
);
   localparam int LANES = CTRL_W / 8;
   localparam logic [CTRL_W-1:0] KEEP = CTRL_W'(1) << BUSY_BIT;
   localparam logic [CTRL_W-1:0] WMSK = CTRL_MASK[CTRL_W-1:0] & ~KEEP;

   logic [CTRL_W-1:0] merged;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*8 +: 8] = lane_we[g] ? wval[g*8 +: 8] : q[g*8 +: 8];
   end

   assign nxt = (merged & WMSK) | (q & KEEP);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   AST_BUSY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(q[BUSY_BIT])); // R2
   AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~(CTRL_MASK[CTRL_W-1:0] | KEEP)) == '0); // R1
endmodule

// File: rtl/cspi_xfer.sv
module cspi_xfer #(
   parameter int CTRL_W   = 16,
   parameter int RX_W     = 8,
   parameter int EN_BIT   = 15,
   parameter int MODE_BIT = 13,
   parameter int HOLD_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl_nxt,
   input  logic              dwr,
   input  logic [RX_W-1:0]   dval,
   input  logic [RX_W-1:0]   slv_rx,
   output logic              slv_valid,
   output logic [RX_W-1:0]   slv_byte,
   output logic              slv_hold,
   output logic [RX_W-1:0]   rx_q
);
   logic gate_open;

   assign gate_open = ctrl_nxt[EN_BIT] & ctrl_nxt[MODE_BIT];
   assign slv_valid = dwr & gate_open;
   assign slv_byte  = dval;
   assign slv_hold  = ctrl_nxt[HOLD_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)         rx_q <= '0;
      else if (slv_valid) rx_q <= slv_rx;
   end

   AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      slv_valid |=> rx_q == $past(slv_rx)); // R4
   AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !slv_valid |=> $stable(rx_q)); // R5
endmodule

// File: rtl/cspi_rd_mux.sv
module cspi_rd_mux
   import cspi_pkg::*;
#(
   parameter int CTRL_W   = 16,
   parameter int RX_W     = 8,
   parameter int EN_BIT   = 15,
   parameter int MODE_BIT = 13
) (
   input  logic              rd,
   input  acc_size_e         size,
   input  logic [1:0]        addr,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic [RX_W-1:0]   rx,
   output logic [BUS_W-1:0]  rdata
);
   localparam int PAD_W = BUS_W - CTRL_W - RX_W;

   logic [RX_W-1:0] data_view;
   logic [BUS_W-1:0] word_view;

   assign data_view = (ctrl[EN_BIT] & ctrl[MODE_BIT]) ? rx : '0;
   assign word_view = {{PAD_W{1'b0}}, data_view, ctrl};

   always_comb begin
      rdata = '0;
      if (rd) begin
         unique case (size)
            SZ_BYTE: rdata = BUS_W'(word_view[addr*8 +: 8]);
            SZ_HALF: if (!addr[0]) rdata = BUS_W'(word_view[addr*8 +: 16]);
            SZ_WORD: if (addr == 2'd0) rdata = word_view;
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/cart_spi_regif.sv
module cart_spi_regif
   import cspi_pkg::*;
#(
   parameter int          CTRL_W    = 16,
   parameter int          RX_W      = 8,
   parameter logic [15:0] CTRL_MASK = 16'hE043,
   parameter int          EN_BIT    = 15,
   parameter int          MODE_BIT  = 13,
   parameter int          HOLD_BIT  = 6,
   parameter int          BUSY_BIT  = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_req,
   input  logic        bus_wr,
   input  logic        bus_cpu,
   input  logic [1:0]  bus_size,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        owner_sel,
   output logic        slv_valid,
   output logic [7:0]  slv_byte,
   output logic        slv_hold,
   input  logic [7:0]  slv_rx
);
   localparam int LANES = CTRL_W / 8;

   if (CTRL_W != 16) begin : g_bad_ctrl
      $error("CTRL_W must be 16");
   end
   if (RX_W != 8) begin : g_bad_rx
      $error("RX_W must be 8");
   end
   if (EN_BIT >= CTRL_W || MODE_BIT >= CTRL_W || HOLD_BIT >= CTRL_W || BUSY_BIT >= CTRL_W) begin : g_bad_bit
      $error("control bit index out of range");
   end

   acc_size_e         size;
   logic              wr, rd, owner_ok, dwr;
   logic [LANES-1:0]  lane_we;
   logic [CTRL_W-1:0] wval, ctrl_q, ctrl_nxt;
   logic [RX_W-1:0]   dval, rx_q;
   logic              unused_hi;

   assign size      = acc_size_e'(bus_size);
   assign wr        = bus_req & bus_wr;
   assign rd        = bus_req & ~bus_wr;
   assign owner_ok  = (bus_cpu == owner_sel);
   assign unused_hi = ^bus_wdata[31:24];

   always_comb begin
      lane_we = '0;
      wval    = bus_wdata[CTRL_W-1:0];
      dwr     = 1'b0;
      dval    = bus_wdata[RX_W-1:0];
      if (wr) begin
         unique case (size)
            SZ_BYTE: begin
               wval = {bus_wdata[7:0], bus_wdata[7:0]};
               if (bus_addr == 2'd0)      lane_we = 2'b01;
               else if (bus_addr == 2'd1) lane_we = 2'b10;
               else if (bus_addr == 2'd2) dwr = 1'b1;
            end
            SZ_HALF: begin
               if (bus_addr == 2'd0)      lane_we = 2'b11;
               else if (bus_addr == 2'd2) dwr = 1'b1;
            end
            SZ_WORD: begin
               if (bus_addr == 2'd0 && owner_ok) begin
                  lane_we = 2'b11;
                  dwr     = 1'b1;
                  dval    = bus_wdata[23:16];
               end
            end
            default: ;
         endcase
      end
      if (!owner_ok) lane_we = '0;
   end

   cspi_ctrl_reg #(.CTRL_W(CTRL_W), .CTRL_MASK(CTRL_MASK), .BUSY_BIT(BUSY_BIT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .wval(wval),
      .q(ctrl_q), .nxt(ctrl_nxt));

   cspi_xfer #(.CTRL_W(CTRL_W), .RX_W(RX_W), .EN_BIT(EN_BIT), .MODE_BIT(MODE_BIT),
               .HOLD_BIT(HOLD_BIT)) u_xfer (
      .clk(clk), .rst_n(rst_n), .ctrl_nxt(ctrl_nxt), .dwr(dwr), .dval(dval),
      .slv_rx(slv_rx), .slv_valid(slv_valid), .slv_byte(slv_byte),
      .slv_hold(slv_hold), .rx_q(rx_q));

   cspi_rd_mux #(.CTRL_W(CTRL_W), .RX_W(RX_W), .EN_BIT(EN_BIT), .MODE_BIT(MODE_BIT)) u_rd (
      .rd(rd), .size(size), .addr(bus_addr), .ctrl(ctrl_q), .rx(rx_q), .rdata(bus_rdata));

   AST_NONOWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !owner_ok && bus_addr[1] == 1'b0) |=> $stable(ctrl_q)); // R6
   AST_XFER_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      slv_valid |-> (bus_req && bus_wr)); // R5
   AST_GATED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && size == SZ_BYTE && bus_addr == 2'd2 && !(ctrl_q[EN_BIT] && ctrl_q[MODE_BIT]))
      |-> bus_rdata == 32'h0); // R3
endmodule

// File: tb/sim_cart_spi_regif.sv
module sim_cart_spi_regif;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_req, bus_wr, bus_cpu, owner_sel;
   logic [1:0]  bus_size, bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        slv_valid, slv_hold;
   logic [7:0]  slv_byte, slv_rx;

   int n_chk = 0, n_err = 0;
   logic [15:0] m_ctrl;
   logic [7:0]  m_rx;
   bit done = 0;

   always #5 clk = ~clk;

   cart_spi_regif u0 (.*);

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] f_next_ctrl(logic wr, logic cpu, logic own, logic [1:0] sz,
                                              logic [1:0] ad, logic [31:0] wd, logic [15:0] cur);
      logic [15:0] v;
      v = cur;
      if (wr && cpu == own) begin
         if (sz == 2'd0 && ad == 2'd0) v[7:0] = wd[7:0];
         if (sz == 2'd0 && ad == 2'd1) v[15:8] = wd[7:0];
         if ((sz == 2'd1 || sz == 2'd2) && ad == 2'd0) v = wd[15:0];
      end
      return (v & 16'hE043) | (cur & 16'h0080);
   endfunction

   function automatic logic [31:0] f_read(logic [1:0] sz, logic [1:0] ad, logic [15:0] c, logic [7:0] rx);
      logic [7:0] d;
      d = (c[15] && c[13]) ? rx : 8'h00;
      case (sz)
         2'd0: case (ad)
                  2'd0: return {24'h0, c[7:0]};
                  2'd1: return {24'h0, c[15:8]};
                  2'd2: return {24'h0, d};
                  default: return 32'h0;
               endcase
         2'd1: return (ad == 2'd0) ? {16'h0, c} : (ad == 2'd2) ? {24'h0, d} : 32'h0;
         2'd2: return (ad == 2'd0) ? {8'h0, d, c} : 32'h0;
         default: return 32'h0;
      endcase
   endfunction

   task automatic op(input logic wr, input logic cpu, input logic own, input logic [1:0] sz,
                     input logic [1:0] ad, input logic [31:0] wd, input string req);
      logic [15:0] nc;
      logic send, ev;
      logic [7:0] db, rxv;
      @(negedge clk);
      bus_req = 1; bus_wr = wr; bus_cpu = cpu; owner_sel = own;
      bus_size = sz; bus_addr = ad; bus_wdata = wd;
      rxv = 8'($urandom); slv_rx = rxv;
      #2;
      nc = f_next_ctrl(wr, cpu, own, sz, ad, wd, m_ctrl);
      send = 0; db = wd[7:0];
      if (wr) begin
         if ((sz == 2'd0 || sz == 2'd1) && ad == 2'd2) send = 1;
         if (sz == 2'd2 && ad == 2'd0 && cpu == own) begin send = 1; db = wd[23:16]; end
      end
      ev = send && nc[15] && nc[13];
      check(slv_valid == ev, {req, " strobe"}, 32'(slv_valid), 32'(ev));
      if (ev) begin
         check(slv_byte == db, {req, " byte"}, 32'(slv_byte), 32'(db));
         check(slv_hold == nc[6], {req, " hold"}, 32'(slv_hold), 32'(nc[6]));
      end
      if (!wr) check(bus_rdata == f_read(sz, ad, m_ctrl, m_rx), {req, " rdata"},
                     bus_rdata, f_read(sz, ad, m_ctrl, m_rx));
      @(posedge clk);
      m_ctrl = nc;
      if (ev) m_rx = rxv;
      #1 bus_req = 0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; bus_req = 0; bus_wr = 0; bus_cpu = 0; owner_sel = 0;
      bus_size = 0; bus_addr = 0; bus_wdata = 0; slv_rx = 0;
      m_ctrl = 0; m_rx = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R9 reset state
      op(0, 0, 0, 2'd2, 2'd0, 0, "R9 reset word read");
      // R1 / R2: all ones written, only mask survives, busy stays 0
      op(1, 0, 0, 2'd1, 2'd0, 32'hFFFF, "R1 mask write");
      op(0, 0, 0, 2'd1, 2'd0, 0, "R1 R2 readback");
      // R6 non-owner control write ignored
      op(1, 1, 0, 2'd1, 2'd0, 32'h0000, "R6 nonowner ctrl");
      op(0, 1, 0, 2'd1, 2'd0, 0, "R6 readback");
      // R5 gate closed: mode bit cleared
      op(1, 0, 0, 2'd1, 2'd0, 32'h8040, "R5 close gate");
      op(1, 0, 0, 2'd0, 2'd2, 32'h5A, "R5 gated data write");
      op(0, 0, 0, 2'd2, 2'd0, 0, "R5 R3 gated read");
      // R4 open gate with hold, data write by non-owner still goes
      op(1, 0, 0, 2'd1, 2'd0, 32'hA040, "R4 open gate");
      op(1, 1, 0, 2'd0, 2'd2, 32'hC3, "R4 R6 data write nonowner");
      op(0, 0, 0, 2'd0, 2'd2, 0, "R3 R4 data read");
      // R7 byte lanes
      op(1, 0, 0, 2'd0, 2'd1, 32'h00, "R7 high byte clear");
      op(0, 0, 0, 2'd1, 2'd0, 0, "R7 low kept");
      op(1, 0, 0, 2'd0, 2'd3, 32'hFF, "R7 offset3 ignored");
      op(1, 0, 0, 2'd0, 2'd0, 32'hFF, "R7 low byte");
      op(0, 0, 0, 2'd0, 2'd0, 0, "R7 low read");
      op(0, 0, 0, 2'd0, 2'd1, 0, "R7 high read");
      // R8 word write opens gate while closed, then closes while open
      op(1, 0, 0, 2'd2, 2'd0, 32'h0077A001, "R8 word opens");
      op(0, 0, 0, 2'd2, 2'd0, 0, "R8 R9 word read");
      op(1, 1, 1, 2'd2, 2'd0, 32'h00110000, "R8 word closes");
      op(1, 0, 1, 2'd2, 2'd0, 32'h0022E043, "R8 nonowner word");
      op(0, 0, 1, 2'd2, 2'd0, 0, "R8 after nonowner");
      for (int i = 0; i < 400; i++) begin
         logic [1:0] sz;
         sz = 2'($urandom_range(0, 2));
         op(1'($urandom), 1'($urandom), 1'($urandom), sz, 2'($urandom),
            ($urandom_range(0, 3) == 0) ? 32'h00FFE043 : $urandom, "R1-rand");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule